// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches the byte stream of an incoming Ethernet frame and decides from its destination address, the first six bytes, whether the frame is kept or discarded. A frame that is dropped takes no receive descriptor further down the path. A frame that is kept also carries a flag telling software whether the address was already confirmed by an exact station match. When that flag is clear, software has to inspect the address itself.

The decision combines a table of station addresses with three mode inputs. Each table entry has its own enable bit. The modes are:
- accept any unicast address,
- accept any group (multicast) address,
- accept the broadcast address.

Bytes arrive one per cycle when `in_valid` is high, and `in_sof` marks the first byte of a frame. A decision is issued once per frame as a single-cycle pulse, shortly after the sixth byte. Anything after the sixth byte (source address, type/length, payload, CRC) passes through without effect. The table is loaded through a simple write port.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_exact` are 0 and every table entry is disabled, so a unicast frame with all modes off is dropped even when its address equals a value later written to the table.
- R2: For each frame, exactly one `dec_valid` pulse of one cycle occurs. The sixth destination byte is sampled at clock edge E, and `dec_valid` is high for the cycle after edge E+1. Outside that pulse, `dec_accept` and `dec_exact` are 0. Bytes after the sixth produce no further pulse.
- R3: A frame whose 48-bit destination equals an enabled table entry is accepted with `dec_exact` = 1. The first byte on the wire maps to address bits [47:40].
- R4: An entry that is disabled, or that differs from the destination in any single bit, gives no exact match.
- R5: With `mode_any_ucast` = 1, every frame whose address bit 40 (bit 0 of the first byte) is 0 is accepted. `dec_exact` is 1 only if the address also hit the table.
- R6: With `mode_any_group` = 1, every frame with address bit 40 = 1 is accepted, and this includes broadcast.
- R7: With `mode_bcast` = 1, the all-ones address is accepted.
- R8: A frame that satisfies none of R3, R5, R6 and R7 is dropped, with `dec_accept` = 0 and `dec_exact` = 0.
- R9: A byte with `in_sof` = 1 restarts address collection at any point. Bytes without `in_sof` are ignored while no frame is being collected. Cycles with `in_valid` = 0 are skipped without losing collected bytes.
- R10: Whenever `dec_exact` is 1, `dec_accept` is also 1, whatever the mode inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is present on `in_data` |
| in_sof | input | 1 | This byte is the first byte of a frame |
| in_data | input | 8 | Frame byte |
| mode_any_ucast | input | 1 | Accept all unicast destinations |
| mode_any_group | input | 1 | Accept all group destinations |
| mode_bcast | input | 1 | Accept the broadcast destination |
| tbl_we | input | 1 | Write a table entry at the next edge |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_en | input | 1 | Enable bit written to the entry |
| tbl_addr | input | 48 | Station address written to the entry |
| dec_valid | output | 1 | Single-cycle decision strobe |
| dec_accept | output | 1 | Frame kept (1) or discarded (0) |
| dec_exact | output | 1 | Acceptance came from an exact table match |

## Verification
The hardest situation to reach from the ports is an address that is one bit away from a stored entry. It must miss, unless the flipped bit happens to land on another stored address. The bench therefore flips each of the 48 bits of one entry in turn. It predicts the outcome from its own copy of the table, so a comparator that ignores a single bit or byte shows up.

The other hard cases are restarts and gaps. A new start-of-frame can arrive in the middle of an address, and bytes can be separated by idle cycles. These are driven with aborted prefixes and gapped bytes. Every mode combination is then crossed with the unicast, group, broadcast, matched and unmatched address classes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int MAC_BYTES = 6;
    localparam int MAC_W     = 8 * MAC_BYTES;
    localparam int GROUP_BIT = MAC_W - 8;   // bit 0 of the first byte on the wire

    typedef logic [MAC_W-1:0] mac_t;

    typedef struct packed {
        logic en;
        mac_t addr;
    } station_t;
endpackage

// File: rtl/rxf_da_collect.sv
module rxf_da_collect
    import rxf_pkg::*;
#(
    parameter int BYTES = MAC_BYTES,
    localparam int CNT_W = $clog2(BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic [7:0]           in_data,
    output logic [8*BYTES-1:0]   da_o,
    output logic                 done_o
);
    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic               busy;
        logic [8*BYTES-1:0] da;
        logic               done;
    } col_t;

    col_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (in_valid) begin
            if (in_sof) begin
                st_d.da   = {st_q.da[8*BYTES-9:0], in_data};
                st_d.cnt  = CNT_W'(1);
                st_d.busy = (BYTES > 1);
                st_d.done = (BYTES == 1);
            end else if (st_q.busy) begin
                st_d.da  = {st_q.da[8*BYTES-9:0], in_data};
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_q.cnt == CNT_W'(BYTES - 1)) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign da_o   = st_q.da;
    assign done_o = st_q.done;

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt < CNT_W'(BYTES)));

    // R2
    done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> $past(in_valid));

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
endmodule

// File: rtl/rxf_match_array.sv
module rxf_match_array
    import rxf_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  mac_t             wr_addr,
    input  mac_t             da_i,
    output logic             hit_o
);
    station_t [N_ENTRIES-1:0] tbl_d, tbl_q;
    logic     [N_ENTRIES-1:0] hit_vec;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (int'(wr_idx) < N_ENTRIES)) begin
            tbl_d[wr_idx].en   = wr_valid;
            tbl_d[wr_idx].addr = wr_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = tbl_q[i].en && (tbl_q[i].addr == da_i);
    end

    assign hit_o = |hit_vec;
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  mac_t da_i,
    input  logic hit_i,
    input  logic any_ucast_i,
    input  logic any_group_i,
    input  logic bcast_i,
    output logic vld_o,
    output logic acc_o,
    output logic exact_o
);
    typedef struct packed {
        logic vld;
        logic acc;
        logic exact;
    } dec_t;

    dec_t dec_d, dec_q;
    logic is_group, is_bcast, by_mode;

    always_comb begin
        is_group = da_i[GROUP_BIT];
        is_bcast = &da_i;
        by_mode  = is_group ? (any_group_i || (is_bcast && bcast_i)) : any_ucast_i;

        dec_d = '0;
        if (done_i) begin
            dec_d.vld   = 1'b1;
            dec_d.exact = hit_i;
            dec_d.acc   = hit_i || by_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign vld_o   = dec_q.vld;
    assign acc_o   = dec_q.acc;
    assign exact_o = dec_q.exact;

    // R10
    exact_implies_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.exact |-> dec_q.acc);

    // R2
    vld_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.vld |-> $past(done_i));

    // R2
    quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_q.vld |-> (!dec_q.acc && !dec_q.exact));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [7:0]       in_data,
    input  logic             mode_any_ucast,
    input  logic             mode_any_group,
    input  logic             mode_bcast,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic             tbl_en,
    input  logic [MAC_W-1:0] tbl_addr,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_exact
);
    mac_t da;
    logic da_done;
    logic hit;

    rxf_da_collect #(.BYTES(MAC_BYTES)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_data  (in_data),
        .da_o     (da),
        .done_o   (da_done)
    );

    rxf_match_array #(.N_ENTRIES(N_ENTRIES)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_valid (tbl_en),
        .wr_addr  (tbl_addr),
        .da_i     (da),
        .hit_o    (hit)
    );

    rxf_decide u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (da_done),
        .da_i        (da),
        .hit_i       (hit),
        .any_ucast_i (mode_any_ucast),
        .any_group_i (mode_any_group),
        .bcast_i     (mode_bcast),
        .vld_o       (dec_valid),
        .acc_o       (dec_accept),
        .exact_o     (dec_exact)
    );

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);
endmodule

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        m_uc = 1'b0, m_gr = 1'b0, m_bc = 1'b0;
    logic        tbl_we = 1'b0, tbl_en = 1'b0;
    logic [3:0]  tbl_idx = '0;
    logic [47:0] tbl_addr = '0;
    logic        dec_valid, dec_accept, dec_exact;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    logic [47:0] mdl_addr [16];
    bit          mdl_en   [16];

    always #5 clk = ~clk;

    rx_addr_filter #(.N_ENTRIES(16)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .mode_any_ucast(m_uc), .mode_any_group(m_gr), .mode_bcast(m_bc),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_en(tbl_en), .tbl_addr(tbl_addr),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_exact(dec_exact)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit mdl_hit(input logic [47:0] da);
        bit h = 1'b0;
        for (int i = 0; i < 16; i++) if (mdl_en[i] && mdl_addr[i] == da) h = 1'b1;
        return h;
    endfunction

    function automatic bit mdl_acc(input logic [47:0] da);
        bit grp = da[40];
        bit bc  = &da;
        if (mdl_hit(da)) return 1'b1;          // R3
        if (!grp) return m_uc;                 // R5
        return m_gr || (bc && m_bc);           // R6, R7
    endfunction

    task automatic write_entry(input int idx, input bit en, input logic [47:0] a);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 4'(idx); tbl_en = en; tbl_addr = a;
        @(negedge clk);
        tbl_we = 1'b0;
        mdl_en[idx] = en; mdl_addr[idx] = a;
    endtask

    task automatic put_byte(input bit sof, input logic [7:0] b, input int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk); in_valid = 1'b0; in_sof = 1'b0;
            chk(dec_valid == 1'b0, "R9 gap", dec_valid, 0);
        end
        @(negedge clk);
        in_valid = 1'b1; in_sof = sof; in_data = b;
    endtask

    // prefix: number of aborted leading bytes (first one with sof) before the real frame
    task automatic frame(input logic [47:0] da, input string req, input int gap, input int prefix);
        bit ea = mdl_acc(da);
        bit ee = mdl_hit(da);
        for (int p = 0; p < prefix; p++) put_byte(p == 0, 8'hC3 ^ 8'(p), 0);
        for (int i = 0; i < 6; i++) put_byte(i == 0, da[47-8*i -: 8], gap);
        @(negedge clk); in_valid = 1'b0; in_sof = 1'b0;
        chk(dec_valid == 1'b0, "R2 early", dec_valid, 0);
        @(negedge clk);
        chk(dec_valid == 1'b1, "R2 pulse", dec_valid, 1);
        chk(dec_accept == ea, req, dec_accept, ea);
        chk(dec_exact == ee, req, dec_exact, ee);
        chk(!(dec_exact && !dec_accept), "R10", {dec_exact, dec_accept}, 2'b11);
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            chk(dec_valid == 1'b0 && dec_accept == 1'b0 && dec_exact == 1'b0,
                "R2 trailing", {dec_valid, dec_accept, dec_exact}, 0);
            in_valid = 1'b1; in_sof = 1'b0; in_data = 8'hFF ^ 8'(t);
        end
        @(negedge clk); in_valid = 1'b0;
        chk(dec_valid == 1'b0, "R2 trailing", dec_valid, 0);
    endtask

    function automatic logic [47:0] ent_addr(input int i);
        return {8'h02, 8'h1B, 8'h00, 8'(i * 17), 8'h5A, 8'(8'h30 + i)};
    endfunction

    localparam logic [47:0] UC_MISS = 48'h02AA_BBCC_DDEE;
    localparam logic [47:0] GR_MISS = 48'h0311_2233_4455;
    localparam logic [47:0] GR_HIT  = 48'h0100_5E00_00FB;
    localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

    initial begin
        #2_000_000;
        if (!done_flag) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin mdl_en[i] = 1'b0; mdl_addr[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dec_valid == 0 && dec_accept == 0 && dec_exact == 0, "R1 outputs",
            {dec_valid, dec_accept, dec_exact}, 0);
        // R1: empty table, modes off -> drop
        frame(ent_addr(2), "R1 empty table", 0, 0);

        for (int i = 0; i < 16; i++) write_entry(i, 1'b1, (i == 15) ? GR_HIT : ent_addr(i));

        // R3: each entry matches
        for (int i = 0; i < 16; i++) frame(mdl_addr[i], "R3 exact", 0, 0);

        // mode sweep across address classes: R5 R6 R7 R8
        for (int m = 0; m < 8; m++) begin
            @(negedge clk);
            m_uc = m[0]; m_gr = m[1]; m_bc = m[2];
            frame(ent_addr(4), "R3 R10 unicast hit", 0, 0);
            frame(UC_MISS, "R5 R8 unicast miss", 0, 0);
            frame(GR_MISS, "R6 R8 group miss", 0, 0);
            frame(GR_HIT,  "R3 R10 group hit", 0, 0);
            frame(BCAST,   "R6 R7 R8 broadcast", 0, 0);
        end
        @(negedge clk); m_uc = 0; m_gr = 0; m_bc = 0;

        // R4: single-bit neighbours of entry 5
        for (int b = 0; b < 48; b++) frame(ent_addr(5) ^ (48'h1 << b), "R4 bit flip", 0, 0);

        // R4: disabled entry
        write_entry(3, 1'b0, ent_addr(3));
        frame(ent_addr(3), "R4 disabled", 0, 0);
        write_entry(3, 1'b1, ent_addr(3));
        frame(ent_addr(3), "R3 re-enabled", 0, 0);

        // R9: stray bytes without sof while idle
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); in_valid = 1'b1; in_sof = 1'b0; in_data = 8'h02;
            chk(dec_valid == 1'b0, "R9 idle bytes", dec_valid, 0);
        end
        @(negedge clk); in_valid = 1'b0;
        chk(dec_valid == 1'b0, "R9 idle bytes", dec_valid, 0);
        // R9: gaps between bytes, restart mid-address
        frame(ent_addr(7), "R9 gaps", 2, 0);
        frame(ent_addr(9), "R9 restart", 0, 3);
        frame(ent_addr(11), "R9 restart gaps", 1, 5);
        @(negedge clk); m_uc = 1'b1;
        frame(UC_MISS, "R9 R5 restart", 3, 4);

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule